// File: doc/BRIEF.md
# Buffer Return Queue Arbiter

This block decides which buffer-return queue of bank 0 is serviced next. Each of up to sixteen queues raises a pending bit. Two things limit the set of queues that may compete. A global return-enable bit must be set, and a count field admits only a contiguous range that starts at queue 0. From the competing queues the arbiter picks one winner. A mode bit selects the policy at run time: fixed priority, where the highest-numbered queue wins, or round-robin.

The winner is registered and held until a downstream `ready` accepts it. The result appears as a one-hot vector and as an encoded index, together with a valid strobe. A grant that is waiting for acceptance keeps its value even if the requests, the mode or the range change. Any such change applies from the next selection onward. The round-robin pointer records the queue of the last accepted grant, so the search for the next winner starts at the queue after it.

Top module: `ret_queue_arbiter`

## Requirements
- R1: During and right after synchronous active-low reset, `grant_valid` is 0 and `grant_vec` is all zeros.
- R2: While `ret_en` is 0, no new grant is issued: a free grant slot stays empty.
- R3: Only queues 0 through `elig_cnt` are eligible (0 admits queue 0 alone, 15 admits all 16). A request from a higher queue never causes a grant.
- R4: With `rr_mode` = 0, the winner is the highest-numbered queue that is requesting and eligible.
- R5: With `rr_mode` = 1, the winner is the first requesting, eligible queue found searching upward from the queue after the last accepted one, wrapping from 15 to 0.
- R6: A new grant appears on the clock edge after the inputs it was chosen from. `grant_vec` has exactly bit `grant_idx` set while `grant_valid` is 1 and is zero otherwise.
- R7: While `grant_valid` is 1 and `ready` is 0, `grant_idx`, `grant_vec` and `grant_valid` hold their values, whatever the requests, mode, range or enable do.
- R8: The round-robin pointer moves only when a grant is accepted (`grant_valid` and `ready` both 1). It resets to queue 15, so queue 0 is searched first after reset.
- R9: When the slot is free and no eligible queue is requesting, `grant_valid` becomes 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 16 | Pending request bit for each queue |
| ret_en | input | 1 | Bank-0 buffer-return enable |
| elig_cnt | input | 4 | Highest eligible queue number |
| rr_mode | input | 1 | 0 = fixed priority, 1 = round-robin |
| ready | input | 1 | Downstream accepts the current grant |
| grant_vec | output | 16 | One-hot grant |
| grant_idx | output | 4 | Encoded granted queue |
| grant_valid | output | 1 | Grant is present |

## Verification
Every result lands exactly one edge after the inputs that produce it. The slot frees in the same cycle a grant is accepted, so a new selection is loaded on the edge that retires the old one. The bench changes its inputs on the falling edge and steps its own reference model once per rising edge. It compares all three outputs at the following falling edge, so each comparison sees the result of exactly one edge. While a grant is held without acceptance, the model expects no change. This makes the stall cycles themselves the checks of the hold rule.

// File: rtl/ret_arb_pkg.sv
// Package: shared helpers for the buffer-return arbiter.
// Assumes queue indices are unsigned and narrower than 32 bits.
package ret_arb_pkg;

    // Build a one-hot vector of width NQ with bit idx set.
    function automatic logic [31:0] idx_onehot(input int unsigned idx);
        logic [31:0] v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/ret_elig_mask.sv
// Module: eligibility mask.
// Passes a request through only when the global enable is set and the
// queue number is at or below the eligibility count. Purely combinational.
module ret_elig_mask #(
    parameter int NUM_Q = 16,
    localparam int IDX_W = $clog2(NUM_Q)
) (
    input  logic [NUM_Q-1:0] req,
    input  logic             ret_en,
    input  logic [IDX_W-1:0] elig_cnt,
    output logic [NUM_Q-1:0] req_ok
);
    // One gate per queue: enable AND in-range AND requesting.
    for (genvar q = 0; q < NUM_Q; q++) begin : g_mask
        assign req_ok[q] = ret_en && (IDX_W'(q) <= elig_cnt) && req[q];
    end
endmodule

// File: rtl/ret_fixed_pick.sv
// Module: fixed-priority picker.
// The highest-numbered set bit of req_ok wins. Combinational.
module ret_fixed_pick #(
    parameter int NUM_Q = 16,
    localparam int IDX_W = $clog2(NUM_Q)
) (
    input  logic [NUM_Q-1:0] req_ok,
    output logic             found,
    output logic [IDX_W-1:0] win_idx,
    output logic [NUM_Q-1:0] win_vec
);
    import ret_arb_pkg::*;

    // Scan upward; the last hit (highest index) overrides earlier ones.
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        for (int q = 0; q < NUM_Q; q++) begin
            if (req_ok[q]) begin
                found   = 1'b1;
                win_idx = IDX_W'(q);
            end
        end
        win_vec = found ? NUM_Q'(idx_onehot(int'(win_idx))) : '0;
    end
endmodule

// File: rtl/ret_rr_pick.sv
// Module: round-robin picker.
// Searches from the queue after last_idx upward and wraps at NUM_Q-1.
// last_idx itself is visited last. Combinational.
module ret_rr_pick #(
    parameter int NUM_Q = 16,
    localparam int IDX_W = $clog2(NUM_Q)
) (
    input  logic [NUM_Q-1:0] req_ok,
    input  logic [IDX_W-1:0] last_idx,
    output logic             found,
    output logic [IDX_W-1:0] win_idx,
    output logic [NUM_Q-1:0] win_vec
);
    import ret_arb_pkg::*;

    int unsigned cand;

    // Visit NUM_Q positions in rotated order; keep the first hit.
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        cand    = 0;
        for (int k = 1; k <= NUM_Q; k++) begin
            cand = (int'(last_idx) + k) % NUM_Q;
            if (!found && req_ok[cand]) begin
                found   = 1'b1;
                win_idx = IDX_W'(cand);
            end
        end
        win_vec = found ? NUM_Q'(idx_onehot(int'(win_idx))) : '0;
    end
endmodule

// File: rtl/ret_queue_arbiter.sv
// Module: buffer-return queue arbiter (top).
// Masks the requests to the eligible range, picks a winner with the policy
// the mode bit selects, and registers it. A grant is held until ready
// accepts it. The round-robin pointer takes the accepted index.
// Assumes NUM_Q is at least 2.
module ret_queue_arbiter #(
    parameter int NUM_Q = 16,
    localparam int IDX_W = $clog2(NUM_Q)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM_Q-1:0] req,
    input  logic             ret_en,
    input  logic [IDX_W-1:0] elig_cnt,
    input  logic             rr_mode,
    input  logic             ready,
    output logic [NUM_Q-1:0] grant_vec,
    output logic [IDX_W-1:0] grant_idx,
    output logic             grant_valid
);
    logic [NUM_Q-1:0] req_ok;
    logic             fx_found, rr_found, sel_found;
    logic [IDX_W-1:0] fx_idx, rr_idx, sel_idx;
    logic [NUM_Q-1:0] fx_vec, rr_vec, sel_vec;
    logic [IDX_W-1:0] rr_ptr, ptr_eff;
    logic             accept, slot_free;

    ret_elig_mask #(.NUM_Q(NUM_Q)) u_mask (
        .req(req), .ret_en(ret_en), .elig_cnt(elig_cnt), .req_ok(req_ok)
    );

    ret_fixed_pick #(.NUM_Q(NUM_Q)) u_fixed (
        .req_ok(req_ok), .found(fx_found), .win_idx(fx_idx), .win_vec(fx_vec)
    );

    ret_rr_pick #(.NUM_Q(NUM_Q)) u_rr (
        .req_ok(req_ok), .last_idx(ptr_eff),
        .found(rr_found), .win_idx(rr_idx), .win_vec(rr_vec)
    );

    // Handshake state and the pointer the round-robin search starts from.
    always_comb begin
        accept    = grant_valid && ready;
        slot_free = !grant_valid || ready;
        ptr_eff   = accept ? grant_idx : rr_ptr;
    end

    // Policy select by the mode bit.
    always_comb begin
        sel_found = rr_mode ? rr_found : fx_found;
        sel_idx   = rr_mode ? rr_idx   : fx_idx;
        sel_vec   = rr_mode ? rr_vec   : fx_vec;
    end

    // Grant register and round-robin pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid <= 1'b0;
            grant_idx   <= '0;
            grant_vec   <= '0;
            rr_ptr      <= IDX_W'(NUM_Q - 1);
        end else begin
            if (accept) begin
                rr_ptr <= grant_idx;
            end
            if (slot_free) begin
                grant_valid <= sel_found;
                grant_idx   <= sel_idx;
                grant_vec   <= sel_vec;
            end
        end
    end

    // R6
    grant_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid ? (grant_vec == (NUM_Q'(1) << grant_idx)) : (grant_vec == '0));

    // R7
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !ready) |=> (grant_valid && $stable(grant_idx) && $stable(grant_vec)));

    // R2
    no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ret_en && slot_free) |=> !grant_valid);

    // R3
    in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_free |=> (!grant_valid || (grant_idx <= $past(elig_cnt))));

    // R3
    was_requested_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_free |=> (!grant_valid || (($past(req) & grant_vec) != '0)));

    // R8
    ptr_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(rr_ptr));

    // R9
    empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_free && (req_ok == '0)) |=> !grant_valid);
endmodule

// File: tb/ret_queue_arbiter_test.sv
// Bench: directed corners plus seeded random traffic, compared every
// cycle against a reference model built from the requirements.
module ret_queue_arbiter_test;
    localparam int NQ = 16;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NQ-1:0] req = '0;
    logic          ret_en = 1'b0;
    logic [IW-1:0] elig_cnt = '0;
    logic          rr_mode = 1'b0;
    logic          ready = 1'b0;
    logic [NQ-1:0] grant_vec;
    logic [IW-1:0] grant_idx;
    logic          grant_valid;

    int checks = 0;
    int fails  = 0;
    int seed_v;

    // Reference model state.
    logic          m_v;
    logic [IW-1:0] m_idx;
    logic [IW-1:0] m_ptr;
    string         m_tag;

    always #2.5 clk = ~clk;

    ret_queue_arbiter #(.NUM_Q(NQ)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .ret_en(ret_en),
        .elig_cnt(elig_cnt), .rr_mode(rr_mode), .ready(ready),
        .grant_vec(grant_vec), .grant_idx(grant_idx), .grant_valid(grant_valid)
    );

    // Requests that pass the enable and the eligible range.
    function automatic logic [NQ-1:0] eligible(input logic [NQ-1:0] r,
                                               input logic en, input logic [IW-1:0] n);
        logic [NQ-1:0] m;
        for (int q = 0; q < NQ; q++) m[q] = en && (q <= n) && r[q];
        return m;
    endfunction

    // Expected winner under the selected policy; returns -1 if none.
    function automatic int winner(input logic [NQ-1:0] e, input logic mode,
                                  input logic [IW-1:0] last);
        if (!mode) begin
            for (int q = NQ - 1; q >= 0; q--) if (e[q]) return q;
        end else begin
            for (int k = 1; k <= NQ; k++) if (e[(last + k) % NQ]) return (last + k) % NQ;
        end
        return -1;
    endfunction

    task automatic check(input string tag, input logic ok, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Advance the model by one rising edge using the present inputs.
    task automatic model_step();
        logic [NQ-1:0] e;
        int w;
        e = eligible(req, ret_en, elig_cnt);
        if (m_v && !ready) begin
            m_tag = "R7";
        end else begin
            if (m_v && ready) m_ptr = m_idx;
            w = winner(e, rr_mode, m_ptr);
            m_v = (w >= 0);
            m_idx = (w >= 0) ? IW'(w) : m_idx;
            if (!ret_en) m_tag = "R2";
            else if (w < 0) m_tag = "R9";
            else if ((req & ~eligible(req, 1'b1, elig_cnt)) != '0) m_tag = "R3";
            else m_tag = rr_mode ? "R5" : "R4";
        end
    endtask

    // One cycle: step model, cross the edge, compare at the falling edge.
    task automatic cycle_check();
        model_step();
        @(posedge clk);
        @(negedge clk);
        check(m_tag, grant_valid == m_v, "grant_valid", int'(grant_valid), int'(m_v));
        if (m_v) check(m_tag, grant_idx == m_idx, "grant_idx", int'(grant_idx), int'(m_idx));
        check("R6", grant_vec == (m_v ? (NQ'(1) << m_idx) : NQ'(0)), "grant_vec",
              int'(grant_vec), m_v ? (1 << m_idx) : 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", !grant_valid && grant_vec == '0, "reset grant",
              int'(grant_valid), 0);
        rst_n = 1'b1;
        m_v = 1'b0; m_idx = '0; m_ptr = IW'(NQ - 1);
    endtask

    initial begin : watchdog
        #(5ns * 150000);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        seed_v = 32'h5eed_0042;
        void'($urandom(seed_v));
        @(negedge clk);
        do_reset();

        // R8: round-robin with every queue requesting starts at queue 0.
        req = '1; ret_en = 1'b1; elig_cnt = 4'd15; rr_mode = 1'b1; ready = 1'b1;
        cycle_check();
        check("R8", grant_idx == 0, "first rr pick", int'(grant_idx), 0);
        // R5: accepted grants rotate 1, 2, ... and wrap past 15.
        for (int i = 0; i < 18; i++) cycle_check();

        // R8: stalled grant leaves the pointer alone.
        ready = 1'b0;
        for (int i = 0; i < 4; i++) cycle_check();
        ready = 1'b1;

        // R4: fixed priority, top queue wins; then a lower range.
        rr_mode = 1'b0;
        for (int i = 0; i < 3; i++) cycle_check();
        elig_cnt = 4'd0; req = 16'h8001;
        for (int i = 0; i < 3; i++) cycle_check();
        // R3: only out-of-range requests.
        req = 16'h8000; elig_cnt = 4'd14;
        for (int i = 0; i < 3; i++) cycle_check();
        // R2: enable off with requests present.
        req = '1; ret_en = 1'b0;
        for (int i = 0; i < 3; i++) cycle_check();
        ret_en = 1'b1;

        // R7: hold while stalled, inputs changing underneath.
        ready = 1'b0;
        cycle_check();
        req = 16'h0003; rr_mode = 1'b1; elig_cnt = 4'd1;
        for (int i = 0; i < 3; i++) cycle_check();
        ready = 1'b1;
        for (int i = 0; i < 3; i++) cycle_check();

        // Random traffic.
        for (int i = 0; i < 4000; i++) begin
            req      = NQ'($urandom);
            if ($urandom % 4 == 0) req = '0;
            ret_en   = ($urandom % 8) != 0;
            elig_cnt = IW'($urandom);
            if ($urandom % 16 == 0) rr_mode = ~rr_mode;
            ready    = ($urandom % 3) != 0;
            cycle_check();
        end

        // R1: reset in the middle of traffic.
        do_reset();
        req = 16'h0006; rr_mode = 1'b1; elig_cnt = 4'd15; ready = 1'b1;
        cycle_check();
        check("R8", grant_idx == 1, "rr after reset", int'(grant_idx), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule